// File: doc/BRIEF.md
# Memory Error Injection Unit

This unit sits on the write path of a memory controller, between the check-bit generator and the DRAM interface. Software programs an address pattern, a check-bit corruption mask, a choice of which half of the check bits to touch, and an injection type. It then arms the unit. Any memory access whose decoded address matches the pattern then leaves with corrupted check bits and/or an inverted data parity bit, so that the downstream error-handling logic can be exercised on demand.

The address pattern has six fields: DIMM index within its channel, rank, channel, bank, page and column. Each field carries its own wildcard bit. A field with its wildcard set matches any value. The data path is combinational, so a corrupted access leaves in the same cycle it arrives. Arming, disarming, the injection count and the status bit update on the clock edge at the end of that access. By default only writes inject. A parameter lets matching reads inject as well.

Top module: `mem_err_inject`

## Requirements
- R1: After reset every match register reads 0x8000_0000 (wildcard bit 31 set, value 0). The mask, section, type, enable, count and status registers all read 0.
- R2: Register map by `cfg_addr`:
  - 0 to 5: match registers for DIMM, rank, channel, bank, page and column, each with the value in the low bits and the wildcard in bit 31.
  - 6: mask.
  - 7: section, in bits [1:0].
  - 8: type, in bits [2:0].
  - 9: enable, in bit 0.
  - 10: injection count.
  - 11: status, in bit 0.
  
  Every configuration field reads back the value written to it.
- R3: An access matches only when every field whose wildcard is clear equals the corresponding access field. Fields with the wildcard set are ignored.
- R4: Writing any nonzero value to register 9 arms the unit. Writing zero disarms it. While disarmed, `out_ecc` equals `acc_ecc` and `out_par` equals `acc_par`.
- R5: When type bit 1 (ECC) is set, a matching access XORs the mask into the check bits selected by the section code:
  - 1 selects the lower half only.
  - 2 selects the upper half only.
  - 3 selects both halves.
  - 0 selects neither.
- R6: When type bit 2 (parity) is set, a matching access inverts the parity bit, independently of the mask.
- R7: With type bit 0 (repeat) clear, the enable clears after the first injection, and later matching accesses pass unchanged.
- R8: With the repeat bit set, every matching access is corrupted until software clears the enable.
- R9: With the default `READ_INJ` of 0, read accesses (`acc_write` = 0) are never corrupted. Cycles with `acc_valid` low are never corrupted.
- R10: Each injection increments the count register, which saturates at its maximum. Each injection also sets the status bit. An arming write clears the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_dimm | input | DIMM_W | DIMM index within channel |
| acc_rank | input | RANK_W | Rank |
| acc_chan | input | CHAN_W | Channel |
| acc_bank | input | BANK_W | Bank |
| acc_page | input | PAGE_W | Page (row) address |
| acc_col | input | COL_W | Column address |
| acc_ecc | input | ECC_W | Check bits from the generator |
| acc_par | input | 1 | Data parity bit |
| out_ecc | output | ECC_W | Check bits toward DRAM, possibly corrupted |
| out_par | output | 1 | Parity toward DRAM, possibly inverted |

## Verification
A wrong match decision or a wrong section mask shows on `out_ecc` in the same cycle as the access. Each table vector is therefore compared against an independently computed expected word. A wrong arming state (a one-shot that fails to clear, or a disarm that does not take effect) appears only on the next matching access, one or more cycles later. For that reason the bench always follows an injection with a second matching access and a readback of the enable register. A wrong count or status stays hidden until software reads it, so these registers are read right after known sequences of injections.

// File: rtl/mem_err_inject.sv
module mem_err_inject #(
  parameter int DIMM_W   = 2,
  parameter int RANK_W   = 2,
  parameter int CHAN_W   = 2,
  parameter int BANK_W   = 3,
  parameter int PAGE_W   = 16,
  parameter int COL_W    = 10,
  parameter int ECC_W    = 8,
  parameter int CNT_W    = 16,
  parameter bit READ_INJ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [DIMM_W-1:0] acc_dimm,
  input  logic [RANK_W-1:0] acc_rank,
  input  logic [CHAN_W-1:0] acc_chan,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic [COL_W-1:0]  acc_col,
  input  logic [ECC_W-1:0]  acc_ecc,
  input  logic              acc_par,
  output logic [ECC_W-1:0]  out_ecc,
  output logic              out_par
);
  localparam int NF = 6;
  localparam int LO = ECC_W / 2;
  localparam int HI = ECC_W - LO;
  localparam logic [3:0] A_MASK = 4'd6, A_SECT = 4'd7, A_TYPE = 4'd8,
                         A_EN = 4'd9, A_CNT = 4'd10, A_STAT = 4'd11;
  localparam logic [30:0] FMASK [NF] = '{
    31'((64'd1 << DIMM_W) - 1), 31'((64'd1 << RANK_W) - 1),
    31'((64'd1 << CHAN_W) - 1), 31'((64'd1 << BANK_W) - 1),
    31'((64'd1 << PAGE_W) - 1), 31'((64'd1 << COL_W) - 1)};

  logic [30:0]      mval [NF];
  logic [NF-1:0]    many;
  logic [ECC_W-1:0] mask;
  logic [1:0]       sect;
  logic [2:0]       itype;
  logic             en, seen;
  logic [CNT_W-1:0] cnt;

  logic [30:0]   fld [NF];
  logic [NF-1:0] fhit;
  logic          hit, arm_wr, en_wr;

  assign fld[0] = 31'(acc_dimm);
  assign fld[1] = 31'(acc_rank);
  assign fld[2] = 31'(acc_chan);
  assign fld[3] = 31'(acc_bank);
  assign fld[4] = 31'(acc_page);
  assign fld[5] = 31'(acc_col);

  for (genvar i = 0; i < NF; i++) begin : g_match
    assign fhit[i] = many[i] | (mval[i] == fld[i]);
  end

  assign hit    = en & acc_valid & (acc_write | READ_INJ) & (&fhit);
  assign en_wr  = cfg_we & (cfg_addr == A_EN);
  assign arm_wr = en_wr & (|cfg_wdata);

  wire [ECC_W-1:0] half = {{HI{sect[1]}}, {LO{sect[0]}}};
  assign out_ecc = acc_ecc ^ ((hit & itype[1]) ? (mask & half) : '0);
  assign out_par = acc_par ^ (hit & itype[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) mval[i] <= '0;
      many  <= '1;
      mask  <= '0;
      sect  <= '0;
      itype <= '0;
      en    <= 1'b0;
      seen  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (hit) begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        seen <= 1'b1;
        if (!itype[0]) en <= 1'b0;
      end
      if (cfg_we) begin
        for (int i = 0; i < NF; i++)
          if (cfg_addr == 4'(i)) begin
            mval[i] <= cfg_wdata[30:0] & FMASK[i];
            many[i] <= cfg_wdata[31];
          end
        case (cfg_addr)
          A_MASK: mask  <= cfg_wdata[ECC_W-1:0];
          A_SECT: sect  <= cfg_wdata[1:0];
          A_TYPE: itype <= cfg_wdata[2:0];
          A_EN: begin
            en <= |cfg_wdata;
            if (|cfg_wdata) seen <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NF; i++)
      if (cfg_addr == 4'(i)) cfg_rdata = {many[i], mval[i]};
    case (cfg_addr)
      A_MASK: cfg_rdata = 32'(mask);
      A_SECT: cfg_rdata = 32'(sect);
      A_TYPE: cfg_rdata = 32'(itype);
      A_EN:   cfg_rdata = 32'(en);
      A_CNT:  cfg_rdata = 32'(cnt);
      A_STAT: cfg_rdata = 32'(seen);
      default: ;
    endcase
  end

  // R4
  pass_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (out_ecc == acc_ecc) && (out_par == acc_par));
  // R4
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && !(|cfg_wdata) |=> !en);
  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !itype[0] && !en_wr |=> !en);
  // R8
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && itype[0] && !en_wr |=> en);
  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (cnt != '1) |=> cnt == $past(cnt) + 1'b1);
  // R10
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> seen);
  // R9
  no_read_inj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || (!acc_write && !READ_INJ)) |-> (out_ecc == acc_ecc) && (out_par == acc_par));
endmodule

// File: tb/tb_mem_err_inject.sv
module tb_mem_err_inject;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        acc_valid = 0, acc_write = 0, acc_par = 0, out_par;
  logic [1:0]  acc_dimm = 0, acc_rank = 0, acc_chan = 0;
  logic [2:0]  acc_bank = 0;
  logic [15:0] acc_page = 0;
  logic [9:0]  acc_col = 0;
  logic [7:0]  acc_ecc = 0, out_ecc;
  int checks = 0, errors = 0;
  bit finished = 0;

  mem_err_inject dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic wr; logic [1:0] dimm; logic [1:0] chan; logic [7:0] ecc; logic [7:0] exp;
  } vec_t;
  // match dimm=1, chan=2; mask 0x41, section 1 (low half), repeat + ECC
  localparam vec_t VEC [6] = '{
    '{1'b1, 2'd1, 2'd2, 8'h00, 8'h01},
    '{1'b1, 2'd0, 2'd2, 8'hAA, 8'hAA},
    '{1'b1, 2'd1, 2'd1, 8'h55, 8'h55},
    '{1'b0, 2'd1, 2'd2, 8'h10, 8'h10},
    '{1'b1, 2'd1, 2'd2, 8'hFF, 8'hFE},
    '{1'b1, 2'd3, 2'd2, 8'h3C, 8'h3C}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic access(logic w, logic [1:0] dm, logic [1:0] ch, logic [7:0] e, logic p,
                        output logic [7:0] oe, output logic op);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_dimm = dm; acc_chan = ch; acc_ecc = e; acc_par = p;
    acc_rank = 2'd3; acc_bank = 3'd5; acc_page = 16'h1234; acc_col = 10'h2A;
    #1 oe = out_ecc; op = out_par;
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] oe;
    logic op;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd0, d); chk("R1 dimm match", d, 32'h8000_0000);
    rd(4'd5, d); chk("R1 col match", d, 32'h8000_0000);
    rd(4'd9, d); chk("R1 enable", d, 0);
    rd(4'd10, d); chk("R1 count", d, 0);
    rd(4'd11, d); chk("R1 status", d, 0);
    // R2 readback
    wr(4'd6, 32'h41); rd(4'd6, d); chk("R2 mask", d, 32'h41);
    wr(4'd7, 32'd1);  rd(4'd7, d); chk("R2 section", d, 1);
    wr(4'd8, 32'd3);  rd(4'd8, d); chk("R2 type", d, 3);
    wr(4'd0, 32'd1);  rd(4'd0, d); chk("R2 dimm value", d, 1);
    wr(4'd2, 32'd2);  rd(4'd2, d); chk("R2 chan value", d, 2);
    // R4 disarmed: no corruption
    access(1, 2'd1, 2'd2, 8'h00, 0, oe, op); chk("R4 disarmed pass", oe, 8'h00);
    wr(4'd9, 32'd7); rd(4'd9, d); chk("R4 arm nonzero", d, 1);
    // R3 R5 R8 R9 table
    foreach (VEC[i]) begin
      access(VEC[i].wr, VEC[i].dimm, VEC[i].chan, VEC[i].ecc, 0, oe, op);
      chk($sformatf("R3/R5/R8/R9 vector %0d", i), oe, VEC[i].exp);
    end
    rd(4'd10, d); chk("R10 count after table", d, 2);
    rd(4'd11, d); chk("R10 status set", d, 1);
    rd(4'd9, d);  chk("R8 still armed", d, 1);
    // R4 disarm
    wr(4'd9, 32'd0);
    access(1, 2'd1, 2'd2, 8'h00, 0, oe, op); chk("R4 disarm pass", oe, 8'h00);
    // R9 invalid cycle with matching fields
    wr(4'd9, 32'd1);
    rd(4'd11, d); chk("R10 status cleared on arm", d, 0);
    @(negedge clk); acc_valid = 0; acc_write = 1; acc_dimm = 1; acc_chan = 2; acc_ecc = 8'h00;
    #1 chk("R9 invalid not corrupted", out_ecc, 8'h00);
    // R5 upper half, R7 one-shot
    wr(4'd0, 32'h8000_0000); wr(4'd2, 32'h8000_0000);
    wr(4'd6, 32'hFF); wr(4'd7, 32'd2); wr(4'd8, 32'd2); wr(4'd9, 32'd1);
    access(1, 2'd0, 2'd0, 8'h00, 0, oe, op); chk("R5 section 2 upper", oe, 8'hF0);
    access(1, 2'd0, 2'd0, 8'h00, 0, oe, op); chk("R7 second access clean", oe, 8'h00);
    rd(4'd9, d); chk("R7 enable self-clear", d, 0);
    // R5 section 3 and 0
    wr(4'd6, 32'h81); wr(4'd7, 32'd3); wr(4'd9, 32'd1);
    access(1, 2'd2, 2'd3, 8'h00, 0, oe, op); chk("R5 section 3 both", oe, 8'h81);
    wr(4'd6, 32'hFF); wr(4'd7, 32'd0); wr(4'd9, 32'd1);
    access(1, 2'd2, 2'd3, 8'h5A, 0, oe, op); chk("R5 section 0 none", oe, 8'h5A);
    // R6 parity only
    wr(4'd8, 32'd4); wr(4'd7, 32'd3); wr(4'd9, 32'd1);
    access(1, 2'd1, 2'd1, 8'h33, 0, oe, op);
    chk("R6 parity inverted", {31'd0, op}, 1);
    chk("R6 ecc untouched", oe, 8'h33);
    rd(4'd10, d); chk("R10 count total", d, 6);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule